// File: doc/BRIEF.md
# Dual-Clock Credit Counter

This block is a counting semaphore shared by two clock domains that have no fixed phase or frequency relation. It behaves like a dual-clock FIFO whose storage has been removed: nothing but the number of outstanding credits crosses between the sides. A producer raises `upReq` to add a credit and must hold off while `upFull` is high. A consumer raises `dnReq` to take a credit. It sees `dnEmpty` and a credit count, `dnCount`.

Each side keeps its own pointer in binary and in Gray code. It passes the Gray copy to the other side through a chain of synchronizer flops. Each chain is reset by the reset of the domain that captures it, so neither side can observe a phantom pointer step when its reset is released.

Both flags are computed from a local pointer and a delayed view of the remote pointer. A flag can therefore clear late, but it never clears early. `DEPTH` must be a power of two and at least 2. The pointers are one bit wider than `log2(DEPTH)`.

Top module: `credit_fifo`

## Requirements
- R1: Once both synchronizer chains have settled, `dnCount` equals the number of accepted up requests minus the number of accepted down requests. No data is stored.
- R2: While `upFull` is low, an up request is accepted on every producer clock edge, including back-to-back cycles.
- R3: `upFull` is high exactly when the producer sees DEPTH outstanding credits. An up request while `upFull` is high is ignored and leaves the count unchanged.
- R4: `dnEmpty` is high when the consumer sees no credits. A down request while `dnEmpty` is high is ignored, and later counting is unaffected.
- R5: Each pointer that crosses domains changes by at most one Gray bit per clock of its own domain.
- R6: While in reset and after reset release, in either order of release, `dnEmpty` is 1, `upFull` is 0 and `dnCount` is 0, with no credit appearing.
- R7: Flags are pessimistic. After a down request on a full counter, `upFull` is still high at the first producer clock that follows, and it clears only after the synchronizer delay.
- R8: `dnCount` never exceeds DEPTH, and `dnEmpty` is high exactly when `dnCount` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| upClk | input | 1 | Producer clock |
| upRstN | input | 1 | Producer asynchronous active-low reset |
| upReq | input | 1 | Add one credit |
| upFull | output | 1 | No room for another credit |
| dnClk | input | 1 | Consumer clock |
| dnRstN | input | 1 | Consumer asynchronous active-low reset |
| dnReq | input | 1 | Take one credit |
| dnEmpty | output | 1 | No credit available |
| dnCount | output | log2(DEPTH)+1 | Credits visible to the consumer |

## Verification
The bench builds the block with DEPTH 4 and a two-flop synchronizer. At that size it can sweep every fill level from zero to two past full, and follow each with every drain length from zero to one past the fill. This covers both wrap-around of the pointers and every ignored request at both ends. The two clocks run at 4 ns and 7 ns with an offset, so the pessimistic window of the full flag after a down request can be observed one producer edge after the consumer edge.

// File: rtl/crf_pkg.sv
`timescale 1ns/1ps
package crf_pkg;
  // Strobes issued by control to the pointer datapath
  typedef struct packed {
    logic upInc;   // advance producer pointer
    logic dnDec;   // advance consumer pointer
  } crf_strobe_t;
endpackage

// File: rtl/crf_sync.sv
`timescale 1ns/1ps
module crf_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage [STAGES];

  // Flops are cleared by the capturing domain's reset
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < STAGES; i++) stage[i] <= '0;
    end else begin
      stage[0] <= d;
      for (int i = 1; i < STAGES; i++) stage[i] <= stage[i-1];
    end
  end

  assign q = stage[STAGES-1];

  initial begin
    a_stages_min: assert (STAGES >= 2) else $error("synchronizer needs two stages");
  end
endmodule

// File: rtl/crf_ctrl.sv
`timescale 1ns/1ps
module crf_ctrl
  import crf_pkg::*;
(
  input  logic        upReq,
  input  logic        upFull,
  input  logic        dnReq,
  input  logic        dnEmpty,
  output crf_strobe_t strb
);
  // Requests at the limits are dropped here (R3, R4)
  always_comb begin
    strb.upInc = upReq & ~upFull;
    strb.dnDec = dnReq & ~dnEmpty;
  end
endmodule

// File: rtl/crf_datapath.sv
`timescale 1ns/1ps
module crf_datapath
  import crf_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int STAGES = 2
) (
  input  logic                   upClk,
  input  logic                   upRstN,
  input  logic                   dnClk,
  input  logic                   dnRstN,
  input  crf_strobe_t            strb,
  output logic                   upFull,
  output logic                   dnEmpty,
  output logic [$clog2(DEPTH):0] dnCount
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;
  localparam logic [PW-1:0] FULL_MASK = PW'(3) << (PW - 2);

  function automatic logic [PW-1:0] toGray(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PW-1:0] fromGray(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [PW-1:0] wrBin, wrGray, wrBinNext;
  logic [PW-1:0] rdBin, rdGray, rdBinNext;
  logic [PW-1:0] wrGraySync, rdGraySync;

  assign wrBinNext = wrBin + PW'(1);
  assign rdBinNext = rdBin + PW'(1);

  // Producer pointer
  always_ff @(posedge upClk or negedge upRstN) begin
    if (!upRstN) begin
      wrBin  <= '0;
      wrGray <= '0;
    end else if (strb.upInc) begin
      wrBin  <= wrBinNext;
      wrGray <= toGray(wrBinNext);
    end
  end

  // Consumer pointer
  always_ff @(posedge dnClk or negedge dnRstN) begin
    if (!dnRstN) begin
      rdBin  <= '0;
      rdGray <= '0;
    end else if (strb.dnDec) begin
      rdBin  <= rdBinNext;
      rdGray <= toGray(rdBinNext);
    end
  end

  crf_sync #(.WIDTH(PW), .STAGES(STAGES)) uRdToUp (
    .clk(upClk), .rstN(upRstN), .d(rdGray), .q(rdGraySync)
  );

  crf_sync #(.WIDTH(PW), .STAGES(STAGES)) uWrToDn (
    .clk(dnClk), .rstN(dnRstN), .d(wrGray), .q(wrGraySync)
  );

  assign upFull  = (wrGray == (rdGraySync ^ FULL_MASK));
  assign dnEmpty = (rdGray == wrGraySync);
  assign dnCount = fromGray(wrGraySync) - rdBin;

  // R3: producer never sees more than DEPTH outstanding
  a_r3_no_overflow: assert property (@(posedge upClk) disable iff (!upRstN)
    (wrBin - fromGray(rdGraySync)) <= PW'(DEPTH));
  // R3: full blocks pointer movement
  a_r3_full_holds: assert property (@(posedge upClk) disable iff (!upRstN)
    upFull |=> $stable(wrBin));
  // R4: empty blocks pointer movement
  a_r4_empty_holds: assert property (@(posedge dnClk) disable iff (!dnRstN)
    dnEmpty |=> $stable(rdBin));
  // R5: single-bit Gray steps on both crossing pointers
  a_r5_wr_gray_step: assert property (@(posedge upClk) disable iff (!upRstN)
    $countones(wrGray ^ $past(wrGray)) <= 1);
  a_r5_rd_gray_step: assert property (@(posedge dnClk) disable iff (!dnRstN)
    $countones(rdGray ^ $past(rdGray)) <= 1);
  // R8: count bound and agreement with empty
  a_r8_count_bound: assert property (@(posedge dnClk) disable iff (!dnRstN)
    dnCount <= PW'(DEPTH));
  a_r8_empty_match: assert property (@(posedge dnClk) disable iff (!dnRstN)
    dnEmpty == (dnCount == '0));
endmodule

// File: rtl/credit_fifo.sv
`timescale 1ns/1ps
module credit_fifo
  import crf_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int STAGES = 2
) (
  input  logic                   upClk,
  input  logic                   upRstN,
  input  logic                   upReq,
  output logic                   upFull,
  input  logic                   dnClk,
  input  logic                   dnRstN,
  input  logic                   dnReq,
  output logic                   dnEmpty,
  output logic [$clog2(DEPTH):0] dnCount
);
  crf_strobe_t strb;

  crf_ctrl uCtrl (
    .upReq(upReq), .upFull(upFull), .dnReq(dnReq), .dnEmpty(dnEmpty), .strb(strb)
  );

  crf_datapath #(.DEPTH(DEPTH), .STAGES(STAGES)) uPath (
    .upClk(upClk), .upRstN(upRstN), .dnClk(dnClk), .dnRstN(dnRstN),
    .strb(strb), .upFull(upFull), .dnEmpty(dnEmpty), .dnCount(dnCount)
  );

  initial begin
    a_depth_pow2: assert (DEPTH >= 2 && (DEPTH & (DEPTH - 1)) == 0)
      else $error("DEPTH must be a power of two, at least 2");
  end
endmodule

// File: tb/credit_fifo_test.sv
`timescale 1ns/100ps
module credit_fifo_test;
  localparam int D = 4;

  logic upClk = 0, dnClk = 0;
  logic upRstN = 0, dnRstN = 0, upReq = 0, dnReq = 0;
  logic upFull, dnEmpty;
  logic [2:0] dnCount;
  int checks = 0, errors = 0;

  credit_fifo #(.DEPTH(D), .STAGES(2)) uut (
    .upClk(upClk), .upRstN(upRstN), .upReq(upReq), .upFull(upFull),
    .dnClk(dnClk), .dnRstN(dnRstN), .dnReq(dnReq), .dnEmpty(dnEmpty),
    .dnCount(dnCount)
  );

  initial forever #2 upClk = ~upClk;
  initial begin #1.3; forever #3.5 dnClk = ~dnClk; end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic doReset();
    upReq = 0; dnReq = 0; upRstN = 0; dnRstN = 0;
    repeat (3) @(negedge upClk);
    repeat (3) @(negedge dnClk);
    upRstN = 1; dnRstN = 1;
    repeat (2) @(negedge dnClk);
  endtask

  task automatic settle();
    repeat (6) @(negedge upClk);
    repeat (6) @(negedge dnClk);
    repeat (2) @(negedge upClk);
  endtask

  task automatic ups(int n);
    if (n > 0) begin
      @(negedge upClk); upReq = 1;
      repeat (n) @(negedge upClk);
      upReq = 0;
    end
  endtask

  task automatic downs(int n);
    if (n > 0) begin
      @(negedge dnClk); dnReq = 1;
      repeat (n) @(negedge dnClk);
      dnReq = 0;
    end
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R6: values during reset
    repeat (2) @(negedge dnClk);
    chk("R6 empty in reset", int'(dnEmpty), 1);
    chk("R6 full in reset", int'(upFull), 0);
    chk("R6 count in reset", int'(dnCount), 0);
    // R6: producer released first, consumer later
    upRstN = 1;
    repeat (5) @(negedge upClk);
    chk("R6 full after up release", int'(upFull), 0);
    dnRstN = 1;
    settle();
    chk("R6 empty after release", int'(dnEmpty), 1);
    chk("R6 count after release", int'(dnCount), 0);
    // R6: consumer released first
    upRstN = 0; dnRstN = 0;
    repeat (3) @(negedge dnClk);
    dnRstN = 1;
    repeat (4) @(negedge dnClk);
    upRstN = 1;
    settle();
    chk("R6 count reverse release", int'(dnCount), 0);
    chk("R6 full reverse release", int'(upFull), 0);

    // R2: back-to-back ups, accepted each cycle until full
    doReset();
    @(negedge upClk); upReq = 1;
    for (int i = 0; i < D; i++) begin
      chk("R2 not full while filling", int'(upFull), 0);
      @(negedge upClk);
    end
    upReq = 0;
    chk("R3 full after DEPTH ups", int'(upFull), 1);
    settle();
    chk("R2 count after burst", int'(dnCount), D);

    // R7: one down on a full counter; full lingers one producer edge
    @(negedge dnClk); dnReq = 1;
    @(posedge dnClk); #1; dnReq = 0;
    @(negedge upClk);
    chk("R7 full still high after down", int'(upFull), 1);
    settle();
    chk("R7 full clears after sync", int'(upFull), 0);
    chk("R7 count after one down", int'(dnCount), D - 1);

    // R1/R3/R4/R5/R8 sweep: fill level by drain length
    for (int n = 0; n <= D + 2; n++) begin
      for (int m = 0; m <= D + 1; m++) begin
        int f, e, g;
        f = (n < D) ? n : D;
        e = (f > m) ? f - m : 0;
        g = (e + 1 < D) ? e + 1 : D;
        doReset();
        ups(n);
        settle();
        chk("R1 R5 count after fill", int'(dnCount), f);
        chk("R3 full after fill", int'(upFull), int'(f == D));
        chk("R8 empty after fill", int'(dnEmpty), int'(f == 0));
        downs(m);
        settle();
        chk("R1 count after drain", int'(dnCount), e);
        chk("R4 empty after drain", int'(dnEmpty), int'(e == 0));
        chk("R3 full after drain", int'(upFull), int'(e == D));
        ups(1);
        settle();
        chk("R4 count after extra up", int'(dnCount), g);
      end
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule